// File: doc/BRIEF.md
# Asymmetric Frame Buffer RAM

This block holds one frame image for a monochrome display that stores one bit per pixel. A processor writes the image through a 32-bit port, and a display controller reads it back through an 8-bit port. A full frame is 200 x 200 pixels. At one bit each that is 40,000 bits, or 5000 bytes, which fits in the 8 KiB byte address space. Inside the stored bytes, a pixel bit of 1 means white and a pixel bit of 0 means black. The block only stores these bits and does not interpret them.

The write address comes from a memory-mapped bus bridge, which sends byte addresses that step by four for each 32-bit word. The block discards the two low address bits, so successive words fill successive word locations. The display side then sees one packed frame with no gaps. Each 32-bit word is stored as four byte lanes in little-endian order. Each byte lane has its own enable, and the byte read port is synchronous.

Top module: `fb_asym_ram`

## Requirements
- R1: On a write, bits [12:2] of `wr_addr_i` select the word, and bits [1:0] have no effect on where data lands.
- R2: Write data bits [8*k+7:8*k] of word w are read back at byte address 4*w+k, for k = 0..3 (little-endian).
- R3: Only the lanes whose `wr_be_i[k]` is 1 are updated. Lanes with a 0 enable keep their previous contents.
- R4: Read data for a byte address presented with `rd_en_i` high at one rising edge is on `rd_data_o` after that edge and holds until the next enabled read.
- R5: If a read and an enabled write hit the same byte at the same edge, the read returns the contents from before the write. The next read of that byte returns the new value.
- R6: While `rd_en_i` is low, `rd_data_o` does not change, even when a write updates the byte last read.
- R7: While `rst_ni` is low and after it is released, `rd_data_o` is 0 until the first enabled read.
- R8: After 1250 consecutive word writes at byte addresses 0, 4, 8, ..., the 5000 bytes of a frame read back packed, at byte addresses 0 to 4999.
- R9: With `wr_en_i` low, no storage changes, whatever `wr_addr_i`, `wr_be_i` and `wr_data_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both ports |
| rst_ni | input | 1 | Active-low asynchronous reset of the read output path |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 13 | Byte address of the word to write, steps by 4 |
| wr_be_i | input | 4 | Byte-lane write enables, bit k for data bits [8k+7:8k] |
| wr_data_i | input | 32 | Write data word |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 13 | Byte address to read |
| rd_data_o | output | 8 | Registered read byte |

## Verification
A read or write takes effect at the edge where it is presented. Read data appears on `rd_data_o` one edge after the read is presented. The bench drives each transaction on a falling edge and works out the expected byte from a byte-wide shadow model. For a collision it applies the model's read before the model's write, and with the read strobe low it expects the previously expected value. It then queues the expected byte, and a monitor compares it 2 ns after the next rising edge, which is exactly one register stage after the stimulus.

// File: rtl/fb_pkg.sv
package fb_pkg;
  localparam int unsigned LANE_W = 8;

  function automatic int unsigned lane_count(input int unsigned word_w);
    return word_w / LANE_W;
  endfunction
endpackage

// File: rtl/fb_addr_split.sv
module fb_addr_split #(
  parameter int unsigned BYTE_ADDR_W = 13,
  parameter int unsigned SEL_W       = 2,
  localparam int unsigned WORD_ADDR_W = BYTE_ADDR_W - SEL_W
) (
  input  logic [BYTE_ADDR_W-1:0] byte_addr_i,
  output logic [WORD_ADDR_W-1:0] word_idx_o,
  output logic [SEL_W-1:0]       lane_sel_o
);
  // step-by-4 bridge addresses become dense word indices
  assign word_idx_o = byte_addr_i[BYTE_ADDR_W-1:SEL_W];
  assign lane_sel_o = byte_addr_i[SEL_W-1:0];
endmodule

// File: rtl/fb_byte_lane.sv
module fb_byte_lane #(
  parameter int unsigned WORD_ADDR_W = 11,
  parameter int unsigned LANE_W      = 8,
  localparam int unsigned DEPTH      = 1 << WORD_ADDR_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [WORD_ADDR_W-1:0] waddr_i,
  input  logic [LANE_W-1:0]      wdata_i,
  input  logic                   re_i,
  input  logic [WORD_ADDR_W-1:0] raddr_i,
  output logic [LANE_W-1:0]      rdata_o
);
  logic [LANE_W-1:0] mem_q [DEPTH];
  logic [LANE_W-1:0] rdata_q;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end

  // nonblocking read sees pre-write contents on a collision
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= mem_q[raddr_i];
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/fb_rd_select.sv
module fb_rd_select #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned SEL_W = $clog2(LANES)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         re_i,
  input  logic [SEL_W-1:0]             sel_i,
  input  logic [LANES-1:0][LANE_W-1:0] lanes_i,
  output logic [LANE_W-1:0]            byte_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   sel_q <= '0;
    else if (re_i) sel_q <= sel_i;
  end

  assign byte_o = lanes_i[sel_q];
endmodule

// File: rtl/fb_asym_ram.sv
module fb_asym_ram #(
  parameter int unsigned BYTE_ADDR_W = 13,
  parameter int unsigned WORD_W      = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [BYTE_ADDR_W-1:0]  wr_addr_i,
  input  logic [WORD_W/8-1:0]     wr_be_i,
  input  logic [WORD_W-1:0]       wr_data_i,
  input  logic                    rd_en_i,
  input  logic [BYTE_ADDR_W-1:0]  rd_addr_i,
  output logic [7:0]              rd_data_o
);
  import fb_pkg::*;

  localparam int unsigned LANES       = lane_count(WORD_W);
  localparam int unsigned SEL_W       = $clog2(LANES);
  localparam int unsigned WORD_ADDR_W = BYTE_ADDR_W - SEL_W;

  logic [WORD_ADDR_W-1:0]        wr_word, rd_word;
  logic [SEL_W-1:0]              wr_lane_unused, rd_lane;
  logic [LANES-1:0][LANE_W-1:0]  lane_rdata;

  fb_addr_split #(.BYTE_ADDR_W(BYTE_ADDR_W), .SEL_W(SEL_W)) u_wr_split (
    .byte_addr_i (wr_addr_i),
    .word_idx_o  (wr_word),
    .lane_sel_o  (wr_lane_unused)
  );

  fb_addr_split #(.BYTE_ADDR_W(BYTE_ADDR_W), .SEL_W(SEL_W)) u_rd_split (
    .byte_addr_i (rd_addr_i),
    .word_idx_o  (rd_word),
    .lane_sel_o  (rd_lane)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fb_byte_lane #(.WORD_ADDR_W(WORD_ADDR_W), .LANE_W(LANE_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .we_i    (wr_en_i && wr_be_i[k]),
      .waddr_i (wr_word),
      .wdata_i (wr_data_i[k*LANE_W +: LANE_W]),
      .re_i    (rd_en_i),
      .raddr_i (rd_word),
      .rdata_o (lane_rdata[k])
    );
  end

  fb_rd_select #(.LANES(LANES), .LANE_W(LANE_W)) u_rd_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .re_i    (rd_en_i),
    .sel_i   (rd_lane),
    .lanes_i (lane_rdata),
    .byte_o  (rd_data_o)
  );
endmodule

// File: rtl/fb_asym_ram_chk.sv
module fb_asym_ram_chk #(
  parameter int unsigned BYTE_ADDR_W = 13,
  parameter int unsigned WORD_W      = 32
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic                   wr_en_i,
  input logic [BYTE_ADDR_W-1:0] wr_addr_i,
  input logic [WORD_W/8-1:0]    wr_be_i,
  input logic [WORD_W-1:0]      wr_data_i,
  input logic                   rd_en_i,
  input logic [BYTE_ADDR_W-1:0] rd_addr_i,
  input logic [7:0]             rd_data_o
);
  localparam int unsigned SEL_W = $clog2(WORD_W / 8);
  localparam int unsigned WA_W  = BYTE_ADDR_W - SEL_W;

  logic              full_q;
  logic [WA_W-1:0]   word_q;
  logic [WORD_W-1:0] data_q;
  logic [7:0]        exp_c;
  logic              hit_c, clash_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      word_q <= '0;
      data_q <= '0;
    end else begin
      full_q <= wr_en_i && (&wr_be_i);
      word_q <= wr_addr_i[BYTE_ADDR_W-1:SEL_W];
      data_q <= wr_data_i;
    end
  end

  assign exp_c   = data_q[rd_addr_i[SEL_W-1:0]*8 +: 8];
  assign hit_c   = full_q && rd_en_i && (rd_addr_i[BYTE_ADDR_W-1:SEL_W] == word_q);
  assign clash_c = wr_en_i && wr_be_i[rd_addr_i[SEL_W-1:0]] &&
                   (wr_addr_i[BYTE_ADDR_W-1:SEL_W] == rd_addr_i[BYTE_ADDR_W-1:SEL_W]);

  // R2
  lane_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_c && !clash_c) |=> (rd_data_o == $past(exp_c)));

  // R5
  old_on_clash_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_c && clash_c) |=> (rd_data_o == $past(exp_c)));

  // R6
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rd_data_o));

  // R7
  reset_zero_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (rd_data_o == 8'h00));
endmodule

bind fb_asym_ram fb_asym_ram_chk #(.BYTE_ADDR_W(BYTE_ADDR_W), .WORD_W(WORD_W)) u_chk (.*);

// File: tb/fb_asym_ram_bench.sv
module fb_asym_ram_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b1;
  logic        wr_en_i = 1'b0;
  logic [12:0] wr_addr_i = '0;
  logic [3:0]  wr_be_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        rd_en_i = 1'b0;
  logic [12:0] rd_addr_i = '0;
  logic [7:0]  rd_data_o;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] model [8192];
  logic [7:0] last_exp = 8'h00;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #4 clk_i = ~clk_i;

  fb_asym_ram u_fb_asym_ram (.*);

  task automatic note(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data_o=%h expected %h", tag, act, exp);
    end
  endtask

  // monitor: results are due one edge after the driven cycle
  always @(posedge clk_i) begin
    #2;
    if (exp_q.size() > 0) note(rd_data_o, exp_q.pop_front(), tag_q.pop_front());
  end

  task automatic cyc(input logic we, input logic [12:0] wa, input logic [3:0] be,
                     input logic [31:0] wd, input logic re, input logic [12:0] ra,
                     input string tag);
    @(negedge clk_i);
    wr_en_i = we; wr_addr_i = wa; wr_be_i = be; wr_data_i = wd;
    rd_en_i = re; rd_addr_i = ra;
    if (re) last_exp = model[ra];
    exp_q.push_back(last_exp);
    tag_q.push_back(tag);
    if (we)
      for (int l = 0; l < 4; l++)
        if (be[l]) model[{wa[12:2], 2'(l)}] = wd[8*l +: 8];
  endtask

  task automatic rd(input logic [12:0] ra, input string tag);
    cyc(1'b0, '0, '0, '0, 1'b1, ra, tag);
  endtask

  initial begin
    #1 rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    #2 note(rd_data_o, 8'h00, "R7 in reset");
    @(negedge clk_i) rst_ni = 1'b1;
    cyc(1'b0, '0, '0, '0, 1'b0, '0, "R7 after reset");

    // R1: fill with misaligned low address bits
    for (int w = 0; w < 2048; w++)
      cyc(1'b1, 13'(w * 4 + (w % 4)), 4'hf, 32'(w) * 32'h9E3779B1 ^ 32'hA5C30F1E,
          1'b0, '0, "R1 fill");

    // R2 R8: packed frame readback
    for (int b = 0; b < 5000; b++) rd(13'(b), "R2 R8 frame");

    // R1 R4: random back-to-back reads
    for (int i = 0; i < 400; i++) rd(13'($urandom_range(0, 8191)), "R1 R4 random");

    // R3: every byte-enable pattern
    for (int be = 0; be < 16; be++) begin
      cyc(1'b1, 13'((100 + be) * 4), 4'(be), $urandom, 1'b0, '0, "R3 write");
      for (int k = 0; k < 4; k++) rd(13'((100 + be) * 4 + k), "R3 lanes");
    end

    // R9: disabled write
    cyc(1'b0, 13'(300 * 4), 4'hf, 32'hDEADBEEF, 1'b0, '0, "R9 write off");
    for (int k = 0; k < 4; k++) rd(13'(300 * 4 + k), "R9 readback");

    // R5: collision returns old, next read returns new
    cyc(1'b1, 13'(400 * 4), 4'hf, 32'h11223344, 1'b1, 13'(400 * 4 + 1), "R5 clash");
    rd(13'(400 * 4 + 1), "R4 R5 after clash");
    cyc(1'b1, 13'(401 * 4), 4'h4, 32'h00AB0000, 1'b1, 13'(401 * 4 + 2), "R5 clash lane2");
    rd(13'(401 * 4 + 2), "R5 new lane2");

    // R6: idle read port holds across a write to the byte last read
    rd(13'(500 * 4 + 3), "R6 prime");
    cyc(1'b1, 13'(500 * 4), 4'hf, 32'hC0FFEE01, 1'b0, 13'(500 * 4 + 3), "R6 hold");
    cyc(1'b0, '0, '0, '0, 1'b0, 13'(7), "R6 hold addr moved");
    rd(13'(500 * 4 + 3), "R6 new value");

    cyc(1'b0, '0, '0, '0, 1'b0, '0, "idle");
    repeat (3) @(posedge clk_i);
    #3;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule